// File: doc/BRIEF.md
# Translation-Table Store Interceptor

This block sits on a core's store path, ahead of the coherent write port. Every store address is compared against two main-memory windows, each given by a base and a limit: one holding the in-memory translation table and one holding the inverse table, which maps host physical pages back to translation-table set addresses. A store that falls outside both windows is passed straight through, in the same cycle. A store into the translation-table window goes through only when the current privilege level is in an allowed set. It then leaves as an ordinary coherent write, so that other holders of the line are invalidated. A store that fails this check is refused and flagged.

A store into the inverse-table window is a dummy write and is never performed as issued. The block holds the store port, reads the inverse entry from memory and takes the translation-table set address stored in that entry. It then issues an invalidating write to that address. A host-side mapping change therefore becomes a coherence event on the guest-virtually indexed table, and that event reaches the cores caching the translation. An inverse entry that is not valid ends the operation with no write.

The redirection runs in a five-state machine. IDLE decodes the store, passes it through or refuses it, and moves to READ_INV on a valid inverse-window store. READ_INV holds the read request until memory accepts it, then moves to WAIT_INV. WAIT_INV waits for the read response and moves to ISSUE_WR if the entry is valid, or to DONE if it is not. ISSUE_WR holds the invalidating write until it is accepted, then moves to DONE. DONE raises the store-port ready for one cycle and returns to IDLE.

Top module: `ttw_interceptor`

## Requirements
- R1: A valid store whose address lies in neither window appears on the write port in the same cycle, with the same address and data and with `wr_inval` low. `st_ready` follows `wr_ready` while the store is pending.
- R2: An address hits a window when base <= addr < limit, compared unsigned. A window whose limit is not above its base matches no address.
- R3: A store to the translation-table window with an allowed privilege is forwarded exactly as in R1. The privilege codes are 0 user, 1 guest supervisor, 2 kernel and 3 hypervisor. Bit i of `ALLOW_MASK` permits code i, and the default mask 4'b1100 allows kernel and hypervisor.
- R4: A store to the translation-table window with a privilege that is not allowed is not forwarded. In that cycle `st_ready` is 1 and `st_fault` is 1.
- R5: A valid store to the inverse-table window (and not to the translation-table window) holds `st_ready` low. From the next cycle it raises `rd_valid`, with `rd_addr` equal to the store address, and keeps both steady until `rd_ready`.
- R6: An inverse entry returns on `rd_resp_data`. Bit AW is its valid flag and bits AW-1:0 are the set address. If the entry is valid, the cycle after `rd_resp_valid` brings one write with `wr_addr` equal to the set address, `wr_data` zero and `wr_inval` 1, held until `wr_ready`.
- R7: If the inverse entry's valid flag is 0, no write is issued. `st_ready` rises in the cycle after the response.
- R8: After the invalidating write is accepted, the next cycle has `st_ready` 1 and `wr_valid` 0, and the block then accepts new stores.
- R9: An address inside both windows is handled as a translation-table store, under R3 or R4, and `overlap_err` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_base | input | AW | Translation-table window base |
| xl_limit | input | AW | Translation-table window limit (exclusive) |
| inv_base | input | AW | Inverse-table window base |
| inv_limit | input | AW | Inverse-table window limit (exclusive) |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted or completed |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_priv | input | PW | Current privilege code |
| st_fault | output | 1 | Store refused by privilege check |
| overlap_err | output | 1 | Store address lies in both windows |
| rd_valid | output | 1 | Inverse entry read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Inverse entry address |
| rd_resp_valid | input | 1 | Read response valid |
| rd_resp_data | input | AW+1 | Inverse entry: valid flag and set address |
| wr_valid | output | 1 | Coherent write valid |
| wr_ready | input | 1 | Coherent write accepted |
| wr_addr | output | AW | Coherent write address |
| wr_data | output | DW | Coherent write data |
| wr_inval | output | 1 | Write is a redirected invalidation |

## Verification
The bench sweeps addresses and privilege codes across three window layouts and takes the expected class of each address from the base/limit arithmetic. The corners it aims at are the exact base and limit addresses, an empty window and overlapping windows. A design with an inclusive limit, or one that lets the inverse window win an overlap, would forward or refuse the wrong store. Redirect transactions run with memory and write-port stalls of several lengths. An interceptor that did not hold its requests, or that wrote to the dummy address rather than to the fetched set address, would show a wrong address or a dropped handshake. The bench also returns invalid inverse entries, so a design that still wrote or never completed would fail.

// File: rtl/ttw_pkg.sv
package ttw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_INV,
        S_WAIT_INV,
        S_ISSUE_WR,
        S_DONE
    } redir_state_t;

    typedef enum logic [1:0] {
        C_PASS,
        C_XLATE_OK,
        C_XLATE_DENY,
        C_INV
    } store_class_t;

    localparam int NUM_WIN = 2;
    localparam int WIN_XLATE = 0;
    localparam int WIN_INV   = 1;

endpackage

// File: rtl/ttw_window_match.sv
module ttw_window_match #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          hit
);
    // half-open interval; limit <= base gives an empty window
    always_comb begin
        hit = (addr >= base) && (addr < limit);
    end
endmodule

// File: rtl/ttw_store_classify.sv
module ttw_store_classify
    import ttw_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          PW         = 2,
    parameter logic [(2**PW)-1:0] ALLOW_MASK = 4'b1100
) (
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] priv,
    input  logic [AW-1:0] xl_base,
    input  logic [AW-1:0] xl_limit,
    input  logic [AW-1:0] inv_base,
    input  logic [AW-1:0] inv_limit,
    output store_class_t  cls,
    output logic          overlap
);
    logic [AW-1:0]      win_base  [NUM_WIN];
    logic [AW-1:0]      win_limit [NUM_WIN];
    logic [NUM_WIN-1:0] win_hit;
    logic               priv_ok;

    always_comb begin
        win_base[WIN_XLATE]  = xl_base;
        win_limit[WIN_XLATE] = xl_limit;
        win_base[WIN_INV]    = inv_base;
        win_limit[WIN_INV]   = inv_limit;
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        ttw_window_match #(.AW(AW)) u_match (
            .addr (addr),
            .base (win_base[w]),
            .limit(win_limit[w]),
            .hit  (win_hit[w])
        );
    end

    always_comb begin
        priv_ok = ALLOW_MASK[priv];
        overlap = &win_hit;
        if (win_hit[WIN_XLATE])
            cls = priv_ok ? C_XLATE_OK : C_XLATE_DENY;
        else if (win_hit[WIN_INV])
            cls = C_INV;
        else
            cls = C_PASS;
    end

    // R9: a translation-window hit always outranks the inverse window
    always_comb begin
        a_prio_r9: assert (!(win_hit[WIN_XLATE] && cls == C_INV));
    end
endmodule

// File: rtl/ttw_redirect_fsm.sv
module ttw_redirect_fsm
    import ttw_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  store_class_t  cls,
    input  logic          overlap,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_fault,
    output logic          overlap_err,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_resp_valid,
    input  logic [AW:0]   rd_resp_data,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_inval
);
    localparam int ENT_VALID = AW;

    redir_state_t  state, nxt;
    logic [AW-1:0] inv_addr_q;
    logic [AW-1:0] set_addr_q;

    // state register and captured addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            inv_addr_q <= '0;
            set_addr_q <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && st_valid && cls == C_INV)
                inv_addr_q <= st_addr;
            if (state == S_WAIT_INV && rd_resp_valid)
                set_addr_q <= rd_resp_data[AW-1:0];
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (st_valid && cls == C_INV) nxt = S_READ_INV;
            S_READ_INV: if (rd_ready) nxt = S_WAIT_INV;
            S_WAIT_INV: if (rd_resp_valid)
                            nxt = rd_resp_data[ENT_VALID] ? S_ISSUE_WR : S_DONE;
            S_ISSUE_WR: if (wr_ready) nxt = S_DONE;
            S_DONE:     nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        st_ready    = 1'b0;
        st_fault    = 1'b0;
        overlap_err = 1'b0;
        rd_valid    = 1'b0;
        rd_addr     = inv_addr_q;
        wr_valid    = 1'b0;
        wr_addr     = st_addr;
        wr_data     = st_data;
        wr_inval    = 1'b0;
        unique case (state)
            S_IDLE: begin
                overlap_err = st_valid && overlap;
                unique case (cls)
                    C_PASS, C_XLATE_OK: begin
                        wr_valid = st_valid;
                        st_ready = wr_ready;
                    end
                    C_XLATE_DENY: begin
                        st_ready = 1'b1;
                        st_fault = st_valid;
                    end
                    C_INV: st_ready = 1'b0;
                    default: st_ready = 1'b0;
                endcase
            end
            S_READ_INV: rd_valid = 1'b1;
            S_WAIT_INV: rd_valid = 1'b0;
            S_ISSUE_WR: begin
                wr_valid = 1'b1;
                wr_addr  = set_addr_q;
                wr_data  = '0;
                wr_inval = 1'b1;
            end
            S_DONE:  st_ready = 1'b1;
            default: st_ready = 1'b0;
        endcase
    end

    p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {S_READ_INV, S_WAIT_INV, S_ISSUE_WR}) |-> !st_ready);

    p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    p_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_INV && rd_resp_valid && rd_resp_data[ENT_VALID])
        |=> (wr_valid && wr_inval && wr_addr == $past(rd_resp_data[AW-1:0])));

    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_inval && !wr_ready) |=> (wr_valid && $stable(wr_addr)));

    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_INV && rd_resp_valid && !rd_resp_data[ENT_VALID])
        |=> (st_ready && !wr_valid));

    p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_inval && wr_ready) |=> (st_ready && !wr_valid));

    p_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_fault |-> (!wr_valid && st_ready));
endmodule

// File: rtl/ttw_interceptor.sv
module ttw_interceptor
    import ttw_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          DW         = 64,
    parameter int          PW         = 2,
    parameter logic [(2**PW)-1:0] ALLOW_MASK = 4'b1100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] xl_base,
    input  logic [AW-1:0] xl_limit,
    input  logic [AW-1:0] inv_base,
    input  logic [AW-1:0] inv_limit,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [PW-1:0] st_priv,
    output logic          st_fault,
    output logic          overlap_err,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_resp_valid,
    input  logic [AW:0]   rd_resp_data,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_inval
);
    store_class_t cls;
    logic         overlap;

    ttw_store_classify #(.AW(AW), .PW(PW), .ALLOW_MASK(ALLOW_MASK)) u_classify (
        .addr     (st_addr),
        .priv     (st_priv),
        .xl_base  (xl_base),
        .xl_limit (xl_limit),
        .inv_base (inv_base),
        .inv_limit(inv_limit),
        .cls      (cls),
        .overlap  (overlap)
    );

    ttw_redirect_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cls          (cls),
        .overlap      (overlap),
        .st_valid     (st_valid),
        .st_ready     (st_ready),
        .st_addr      (st_addr),
        .st_data      (st_data),
        .st_fault     (st_fault),
        .overlap_err  (overlap_err),
        .rd_valid     (rd_valid),
        .rd_ready     (rd_ready),
        .rd_addr      (rd_addr),
        .rd_resp_valid(rd_resp_valid),
        .rd_resp_data (rd_resp_data),
        .wr_valid     (wr_valid),
        .wr_ready     (wr_ready),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_inval     (wr_inval)
    );
endmodule

// File: tb/tb_ttw_interceptor.sv
`timescale 1ns/1ps
module tb_ttw_interceptor;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] xl_base, xl_limit, inv_base, inv_limit;
    logic          st_valid, st_ready;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic [PW-1:0] st_priv;
    logic          st_fault, overlap_err;
    logic          rd_valid, rd_ready;
    logic [AW-1:0] rd_addr;
    logic          rd_resp_valid;
    logic [AW:0]   rd_resp_data;
    logic          wr_valid, wr_ready;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          wr_inval;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ttw_interceptor #(.AW(AW), .DW(DW), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n),
        .xl_base(xl_base), .xl_limit(xl_limit),
        .inv_base(inv_base), .inv_limit(inv_limit),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_priv(st_priv),
        .st_fault(st_fault), .overlap_err(overlap_err),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_inval(wr_inval)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // bundle of outputs for compact compare
    function automatic logic [31:0] obs_pack();
        return {wr_valid, st_ready, st_fault, overlap_err, wr_inval, rd_valid,
                2'b0, wr_addr, wr_data[11:0]};
    endfunction

    task automatic sweep_cfg(input logic [AW-1:0] xb, input logic [AW-1:0] xlim,
                             input logic [AW-1:0] ib, input logic [AW-1:0] ilim);
        xl_base = xb; xl_limit = xlim; inv_base = ib; inv_limit = ilim;
        for (int a = 0; a < 256; a++) begin
            for (int p = 0; p < 4; p++) begin
                logic [AW-1:0] ad;
                bit in_x, in_i, ok_p, wr_r;
                logic [31:0] exp;
                string req;
                ad   = AW'(a * 16 + (p & 1) * 15);
                in_x = (ad >= xb) && (ad < xlim);
                in_i = (ad >= ib) && (ad < ilim);
                ok_p = (p >= 2);
                wr_r = ((a + p) % 3) != 0;
                if (in_i && !in_x) continue;
                @(negedge clk);
                st_valid = 1'b1; st_addr = ad; st_priv = PW'(p);
                st_data = DW'(a * 257 + p * 31 + 5); wr_ready = wr_r;
                #2;
                if (!in_x) begin
                    req = "R1/R2";
                    exp = {1'b1, wr_r, 1'b0, 1'b0, 1'b0, 1'b0, 2'b0, ad, st_data[11:0]};
                end else if (ok_p) begin
                    req = in_i ? "R9/R3" : "R3/R2";
                    exp = {1'b1, wr_r, 1'b0, in_i, 1'b0, 1'b0, 2'b0, ad, st_data[11:0]};
                end else begin
                    req = in_i ? "R9/R4" : "R4/R2";
                    exp = {1'b0, 1'b1, 1'b1, in_i, 1'b0, 1'b0, 2'b0, 12'h0, 12'h0};
                end
                if (!(in_x && !ok_p))
                    chk(obs_pack() == exp, req, "sweep outputs", obs_pack(), exp);
                else
                    chk(obs_pack()[31:24] == exp[31:24], req, "refused outputs",
                        {24'h0, obs_pack()[31:24]}, {24'h0, exp[31:24]});
                @(posedge clk);
            end
        end
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_inv(input logic [AW-1:0] ad, input bit ent_v,
                          input logic [AW-1:0] set_a, input int rd_lat, input int wr_lat);
        @(negedge clk);
        st_valid = 1'b1; st_addr = ad; st_priv = 2'd3; st_data = 16'hDEAD;
        rd_ready = 1'b0; wr_ready = 1'b0; rd_resp_valid = 1'b0;
        #2;
        chk(!st_ready && !wr_valid, "R5", "stall on dummy write", {st_ready, wr_valid}, 0);
        @(posedge clk);
        for (int i = 0; i <= rd_lat; i++) begin
            @(negedge clk);
            rd_ready = (i == rd_lat);
            #2;
            chk(rd_valid && rd_addr == ad && !st_ready, "R5", "read request held",
                {rd_valid, st_ready, 2'b0, rd_addr}, {1'b1, 1'b0, 2'b0, ad});
            @(posedge clk);
        end
        @(negedge clk);
        rd_ready = 1'b0;
        rd_resp_valid = 1'b1; rd_resp_data = {ent_v, set_a};
        #2;
        chk(!rd_valid && !st_ready && !wr_valid, "R5", "waiting for entry",
            {rd_valid, st_ready, wr_valid}, 0);
        @(posedge clk);
        @(negedge clk);
        rd_resp_valid = 1'b0; rd_resp_data = '0;
        if (ent_v) begin
            for (int i = 0; i <= wr_lat; i++) begin
                if (i > 0) @(negedge clk);
                wr_ready = (i == wr_lat);
                #2;
                chk(wr_valid && wr_inval && wr_addr == set_a && wr_data == 0 && !st_ready,
                    "R6", "redirected write",
                    {wr_valid, wr_inval, st_ready, 1'b0, wr_addr, wr_data},
                    {1'b1, 1'b1, 1'b0, 1'b0, set_a, 16'h0});
                @(posedge clk);
            end
            @(negedge clk);
            wr_ready = 1'b0;
            #2;
            chk(st_ready && !wr_valid, "R8", "completion after write",
                {st_ready, wr_valid}, 2'b10);
        end else begin
            #2;
            chk(st_ready && !wr_valid, "R7", "invalid entry dropped",
                {st_ready, wr_valid}, 2'b10);
        end
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0;
        #2;
        chk(!rd_valid && !wr_valid && !st_ready, "R8", "back to idle",
            {rd_valid, wr_valid, st_ready}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        xl_base = 12'h100; xl_limit = 12'h200; inv_base = 12'h300; inv_limit = 12'h380;
        st_valid = 0; st_addr = 0; st_data = 0; st_priv = 0;
        rd_ready = 0; rd_resp_valid = 0; rd_resp_data = 0; wr_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!rd_valid && !wr_valid && !st_fault, "R1", "reset state",
            {rd_valid, wr_valid, st_fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_valid && !wr_valid, "R5", "idle after reset", {rd_valid, wr_valid}, 0);

        // disjoint windows
        sweep_cfg(12'h100, 12'h200, 12'h300, 12'h380);
        // overlapping windows
        sweep_cfg(12'h100, 12'h200, 12'h180, 12'h280);
        // empty translation window (limit == base) and inverted inverse window
        sweep_cfg(12'h200, 12'h200, 12'h500, 12'h400);

        xl_base = 12'h100; xl_limit = 12'h200; inv_base = 12'h300; inv_limit = 12'h380;
        for (int k = 0; k < 12; k++) begin
            logic [AW-1:0] ad;
            ad = (k == 0) ? 12'h300 : (k == 1) ? 12'h37F : AW'(12'h300 + k * 9);
            do_inv(ad, (k % 4) != 3, AW'(12'h800 + k * 37), k % 3, (k + 1) % 4);
        end
        // R9: overlap region goes to translation path, not redirection
        inv_base = 12'h180; inv_limit = 12'h280;
        @(negedge clk);
        st_valid = 1'b1; st_addr = 12'h1A0; st_priv = 2'd2; wr_ready = 1'b1;
        #2;
        chk(wr_valid && !rd_valid && overlap_err && !wr_inval, "R9", "overlap forwarded",
            {wr_valid, rd_valid, overlap_err, wr_inval}, 4'b1010);
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0;
        #2;
        chk(!rd_valid, "R9", "no redirection after overlap", {31'h0, rd_valid}, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule